// File: doc/BRIEF.md
# Rotate and Shift Unit with Flag Byte

This block computes the eight single-bit rotate and shift operations of an 8-bit accumulator-style CPU's bit-manipulation group. It also builds the complete flag byte that such an operation leaves behind. It takes an 8-bit operand, a 3-bit operation code and the incoming carry flag. It returns the shifted byte and the new flag byte. The flag byte includes the two undocumented bits that copy result bits 5 and 3. The set includes the rarely documented left shift that shifts a 1 into bit 0.

The datapath is purely combinational. A thin registered wrapper captures the datapath outputs when `in_valid` is high and raises `out_valid` one cycle later. This lets the block sit on a pipeline boundary. Operand fetch, register selection, memory access and instruction timing belong to the surrounding core.

Top module: `rot_shift_unit`

## Requirements
- R1: After reset `out_valid`, `result` and `flags` are 0; `out_valid` is high in exactly the cycle after each cycle with `in_valid` high (one cycle of latency) and low otherwise.
- R2: Operation code 0 (circular left): result = {a[6:0], a[7]}, carry out = a[7].
- R3: Operation code 1 (circular right): result = {a[0], a[7:1]}, carry out = a[0].
- R4: Operation codes 2 and 3 rotate through carry: code 2 gives {a[6:0], carry_in} with carry out a[7]; code 3 gives {carry_in, a[7:1]} with carry out a[0].
- R5: Operation code 4 (arithmetic left): result = {a[6:0], 0}, carry out = a[7].
- R6: Operation code 5 (arithmetic right): result = {a[7], a[7:1]}, carry out = a[0].
- R7: Operation code 6 (left shift filling one): result = {a[6:0], 1}, carry out = a[7].
- R8: Operation code 7 (logical right): result = {0, a[7:1]}, carry out = a[0].
- R9: The flag byte layout is as follows. Bit 0 is the carry out and bit 6 is 1 when the result is zero. Bit 2 is 1 when the result has an even number of ones. Bits 7, 5 and 3 equal result bits 7, 5 and 3. Bits 4 and 1 are 0.
- R10: While `in_valid` is low, `result` and `flags` keep their last captured values whatever the other inputs do.
- R11: For all operation codes other than 2 and 3, `carry_in` has no effect on `result` or `flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture strobe for operand, code and carry |
| operand | input | 8 | Byte to rotate or shift |
| op_sel | input | 3 | Operation code 0..7 |
| carry_in | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result and flags updated this cycle |
| result | output | 8 | Registered rotated/shifted byte |
| flags | output | 8 | Registered flag byte |

## Verification
The bench sweeps every operand with every code and both carry values. This catches a fill bit that is taken from the wrong source. For example, an arithmetic right shift that clears bit 7 would corrupt negative operands. A one-filling shift that inserts 0 would return an arithmetic-left result. Operands 0x00, 0x01 and 0x80 are aimed at the zero flag and at the carry edge. With these operands, a design that tests zero before the shift, or takes carry from the wrong end, shows a wrong flag byte. Parity and the copied bits 5 and 3 are compared as a whole byte, so an odd-parity polarity or a missing copy shows up. Idle gaps with the inputs still toggling check that the wrapper holds its value and that the strobe latency is one cycle.

// File: rtl/rsu_pkg.sv
package rsu_pkg;

    localparam int DATA_W = 8;
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ROT_L    = 3'd0,
        OP_ROT_R    = 3'd1,
        OP_ROTC_L   = 3'd2,
        OP_ROTC_R   = 3'd3,
        OP_ASH_L    = 3'd4,
        OP_ASH_R    = 3'd5,
        OP_ONE_L    = 3'd6,
        OP_LSH_R    = 3'd7
    } shift_op_e;

    // flag byte, MSB first: sign, zero, copy5, half, copy3, parity, sub, carry
    typedef struct packed {
        logic sign;
        logic zero;
        logic copy5;
        logic half;
        logic copy3;
        logic parity;
        logic sub;
        logic carry;
    } flag_byte_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              cout;
    } shift_out_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        flag_byte_t        flg;
    } unit_out_t;

    // even parity of a byte: 1 when the count of ones is even
    function automatic logic even_parity(input logic [DATA_W-1:0] v);
        return ~(^v);
    endfunction

    // right-going operations are the odd codes
    function automatic logic is_right(input shift_op_e op);
        return op[0];
    endfunction

endpackage

// File: rtl/rsu_shift_core.sv
module rsu_shift_core
    import rsu_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  shift_op_e         op,
    input  logic              cin,
    output shift_out_t        y
);

    localparam int MSB = DATA_W - 1;

    logic              fill_l;
    logic              fill_r;
    logic [DATA_W-1:0] left_v;
    logic [DATA_W-1:0] right_v;

    // bit entering the vacated LSB on a left move
    always_comb begin
        unique case (op)
            OP_ROT_L:  fill_l = a[MSB];
            OP_ROTC_L: fill_l = cin;
            OP_ONE_L:  fill_l = 1'b1;
            default:   fill_l = 1'b0;
        endcase
    end

    // bit entering the vacated MSB on a right move
    always_comb begin
        unique case (op)
            OP_ROT_R:  fill_r = a[0];
            OP_ROTC_R: fill_r = cin;
            OP_ASH_R:  fill_r = a[MSB];
            default:   fill_r = 1'b0;
        endcase
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_bits
        if (i == 0) begin : g_lsb
            assign left_v[i]  = fill_l;
            assign right_v[i] = a[i+1];
        end else if (i == MSB) begin : g_msb
            assign left_v[i]  = a[i-1];
            assign right_v[i] = fill_r;
        end else begin : g_mid
            assign left_v[i]  = a[i-1];
            assign right_v[i] = a[i+1];
        end
    end

    always_comb begin
        if (is_right(op)) begin
            y.data = right_v;
            y.cout = a[0];
        end else begin
            y.data = left_v;
            y.cout = a[MSB];
        end
    end

endmodule

// File: rtl/rsu_flag_gen.sv
module rsu_flag_gen
    import rsu_pkg::*;
(
    input  logic [DATA_W-1:0] r,
    input  logic              cout,
    output flag_byte_t        f
);

    always_comb begin
        f        = '0;
        f.sign   = r[7];
        f.zero   = (r == '0);
        f.copy5  = r[5];
        f.half   = 1'b0;
        f.copy3  = r[3];
        f.parity = even_parity(r);
        f.sub    = 1'b0;
        f.carry  = cout;
    end

endmodule

// File: rtl/rot_shift_unit.sv
module rot_shift_unit
    import rsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        operand,
    input  logic [2:0]        op_sel,
    input  logic              carry_in,
    output logic              out_valid,
    output logic [7:0]        result,
    output logic [7:0]        flags
);

    shift_op_e  op_e;
    shift_out_t sh;
    flag_byte_t fl;
    unit_out_t  comb_out;
    unit_out_t  reg_out;
    logic       vld_q;

    assign op_e = shift_op_e'(op_sel);

    rsu_shift_core u_core (
        .a   (operand),
        .op  (op_e),
        .cin (carry_in),
        .y   (sh)
    );

    rsu_flag_gen u_flags (
        .r    (sh.data),
        .cout (sh.cout),
        .f    (fl)
    );

    assign comb_out.data = sh.data;
    assign comb_out.flg  = fl;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q   <= 1'b0;
            reg_out <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                reg_out <= comb_out;
            end
        end
    end

    assign out_valid = vld_q;
    assign result    = reg_out.data;
    assign flags     = reg_out.flg;

endmodule

// File: rtl/rot_shift_unit_chk.sv
module rot_shift_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [7:0] operand,
    input logic [2:0] op_sel,
    input logic       carry_in,
    input logic       out_valid,
    input logic [7:0] result,
    input logic [7:0] flags
);

    // R1
    strobe_latency_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R1
    strobe_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R2
    rot_left_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 3'd0) |=>
        (result == {$past(operand[6:0]), $past(operand[7])}));

    // R4
    rotc_right_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 3'd3) |=>
        (result == {$past(carry_in), $past(operand[7:1])}));

    // R6
    ash_right_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 3'd5) |=> (result[7] == $past(operand[7])));

    // R7
    one_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 3'd6) |=> result[0]);

    // R9
    carry_end_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (flags[0] == ($past(op_sel[0]) ? $past(operand[0])
                                                    : $past(operand[7]))));

    // R9
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (flags[6] == (result == 8'h00)));

    // R9
    copy_bits_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (flags[7] == result[7] && flags[5] == result[5] &&
                       flags[3] == result[3] && !flags[4] && !flags[1]));

    // R9
    parity_flag_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (flags[2] == ($countones(result) % 2 == 0)));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(flags)));

endmodule

bind rot_shift_unit rot_shift_unit_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .operand   (operand),
    .op_sel    (op_sel),
    .carry_in  (carry_in),
    .out_valid (out_valid),
    .result    (result),
    .flags     (flags)
);

// File: tb/rot_shift_unit_tb_top.sv
module rot_shift_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [7:0] operand;
    logic [2:0] op_sel;
    logic       carry_in;
    logic       out_valid;
    logic [7:0] result;
    logic [7:0] flags;

    always #10 clk = ~clk;

    rot_shift_unit dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .operand   (operand),
        .op_sel    (op_sel),
        .carry_in  (carry_in),
        .out_valid (out_valid),
        .result    (result),
        .flags     (flags)
    );

    typedef struct {
        logic [7:0] res;
        logic [7:0] flg;
        string      tag;
    } exp_t;

    exp_t       q[$];
    int         total = 0;
    int         bad   = 0;
    logic [7:0] last_res = 8'h00;
    logic [7:0] last_flg = 8'h00;

    function automatic exp_t model(logic [7:0] a, logic [2:0] op, logic c);
        exp_t e;
        logic [7:0] r;
        logic co;
        case (op)
            3'd0: begin r = {a[6:0], a[7]}; co = a[7]; e.tag = "R2"; end
            3'd1: begin r = {a[0], a[7:1]}; co = a[0]; e.tag = "R3"; end
            3'd2: begin r = {a[6:0], c};    co = a[7]; e.tag = "R4"; end
            3'd3: begin r = {c, a[7:1]};    co = a[0]; e.tag = "R4"; end
            3'd4: begin r = {a[6:0], 1'b0}; co = a[7]; e.tag = "R5"; end
            3'd5: begin r = {a[7], a[7:1]}; co = a[0]; e.tag = "R6"; end
            3'd6: begin r = {a[6:0], 1'b1}; co = a[7]; e.tag = "R7"; end
            default: begin r = {1'b0, a[7:1]}; co = a[0]; e.tag = "R8"; end
        endcase
        // R11: carry set on a code that must ignore it; same expected value
        if (c && op != 3'd2 && op != 3'd3) e.tag = {e.tag, "/R11"};
        e.res = r;
        e.flg = {r[7], (r == 8'h00), r[5], 1'b0, r[3],
                 ($countones(r) % 2 == 0), 1'b0, co};
        return e;
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic send(logic [7:0] a, logic [2:0] op, logic c);
        @(posedge clk);
        #2;
        in_valid = 1'b1;
        operand  = a;
        op_sel   = op;
        carry_in = c;
        q.push_back(model(a, op, c));
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #2;
            in_valid = 1'b0;
            operand  = operand ^ 8'h5A;
            op_sel   = op_sel + 3'd3;
            carry_in = ~carry_in;
        end
    endtask

    // monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (q.size() == 0) begin
                check("R1 unexpected out_valid", 8'h01, 8'h00);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, result, e.res);
                check("R9", flags, e.flg);
                last_res = e.res;
                last_flg = e.flg;
            end
        end
    end

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        rst      = 1'b1;
        in_valid = 1'b0;
        operand  = 8'hA5;
        op_sel   = 3'd0;
        carry_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 reset out_valid", {7'd0, out_valid}, 8'h00);
        check("R1 reset result", result, 8'h00);
        check("R1 reset flags", flags, 8'h00);
        @(posedge clk);
        #2;
        rst = 1'b0;

        // directed corners: zero results, carry edges, sign fill
        send(8'h00, 3'd0, 1'b0);   // R2 zero result, Z set
        send(8'h80, 3'd4, 1'b0);   // R5 shifts to zero with carry
        send(8'h01, 3'd7, 1'b0);   // R8 shifts to zero with carry
        send(8'h80, 3'd5, 1'b0);   // R6 sign kept
        send(8'h00, 3'd6, 1'b0);   // R7 never zero
        send(8'h00, 3'd2, 1'b1);   // R4 carry enters bit 0
        send(8'h00, 3'd3, 1'b1);   // R4 carry enters bit 7
        send(8'h01, 3'd1, 1'b0);   // R3 bit 0 wraps to bit 7
        idle(2);
        // R1: strobe low gives no output
        @(negedge clk);
        check("R1 idle out_valid", {7'd0, out_valid}, 8'h00);

        // exhaustive sweep with periodic gaps
        for (int op = 0; op < 8; op++) begin
            for (int c = 0; c < 2; c++) begin
                for (int a = 0; a < 256; a++) begin
                    send(a[7:0], op[2:0], c[0]);
                    if (a % 37 == 36) idle(1);
                end
            end
        end
        idle(3);
        @(negedge clk);
        check("R1 queue drained", 8'(q.size()), 8'h00);

        // R10: hold while strobe low and inputs toggle
        send(8'h96, 3'd0, 1'b0);
        idle(6);
        @(negedge clk);
        check("R10 hold result", result, last_res);
        check("R10 hold flags", flags, last_flg);
        check("R10 hold value", result, 8'h2D);

        finish_run();
    end

endmodule